// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Entry Word Queue

This block recovers words from a single asynchronous serial line. A frame is one low start bit, then 8 or 9 data bits with the least significant bit first, then one high stop bit. An internal tick runs at a fixed multiple of the bit rate. A receive state machine uses this tick to check the start bit at its midpoint, sample each data bit at its centre and assemble the word in a shift register. Each finished word goes into a two-entry first-in first-out queue together with its ninth bit and its stop-bit status. The host sees the head entry on the read outputs and pops it with a one-cycle read strobe.

The queue holds two words while a third is still being shifted in. If a third word completes while both entries are occupied, that word is dropped, the overrun flag is raised and reception stops. Dropping the receive enable clears the flag and restarts the state machine. The queued words are kept. An interrupt request follows data-available, gated by an interrupt enable.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset, data_avail, overrun and irq are 0.
- R2: One bit period lasts OVERSAMPLE ticks, and a tick occurs once every TICK_DIV clocks. A frame with a 0 start bit, 8 data bits (least significant bit first) and a 1 stop bit delivers that byte on rd_data, with rd_bit9 = 0 and rd_frame_err = 0.
- R3: A low level on the line that is gone before the middle of the start bit is rejected. No word is stored, and the next valid frame is received normally.
- R4: With nine_bit_en = 1, a ninth data bit follows the eighth. It appears on rd_bit9 next to its byte. Each queue entry keeps its own ninth bit.
- R5: If the stop bit is sampled as 0, the word is still stored and its entry carries rd_frame_err = 1. After such a frame the receiver waits for the line to return high before it looks for a new start bit.
- R6: The queue holds up to 2 words in arrival order. data_avail is 1 exactly while it is non-empty. A rd_en pulse removes the head entry, and rd_en while empty has no effect.
- R7: If a frame completes while the queue holds 2 words, that word is discarded and overrun becomes 1. Later frames are ignored while overrun is 1, and the queued words stay readable.
- R8: While rx_enable = 0, overrun is cleared, the receive state machine is held idle and frames are not received. Queue contents survive the disable.
- R9: irq is 1 exactly when data_avail = 1 and irq_en = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial data line, idle high |
| rx_enable | input | 1 | Continuous receive enable; low clears overrun |
| nine_bit_en | input | 1 | Receive a ninth data bit per frame |
| irq_en | input | 1 | Receive interrupt enable |
| rd_en | input | 1 | Pop the head queue entry |
| rd_data | output | DATA_W | Data byte of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rd_frame_err | output | 1 | Stop-bit error of the head entry |
| data_avail | output | 1 | Queue holds at least one word |
| overrun | output | 1 | A word was lost; reception halted |
| irq | output | 1 | Receive interrupt request |

## Verification
Every 8-bit value is sent in complementary pairs (v, 255-v) and read back two at a time. This separates a bit-order or bit-position fault from a queue-ordering fault. A stride sweep over 9-bit values alternates the ninth bit between neighbouring entries, so a ninth bit that is shared instead of stored per entry shows up. Short low glitches, bad stop bits, a third frame into a full queue, frames sent while disabled, and a read strobe on an empty queue each separate one control path from the plain data path.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_STOP  = 3'd3,
      RX_BREAK = 3'd4,
      RX_HALT  = 3'd5
   } rx_state_e;

endpackage

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV < 1) begin : g_bad
         $error("TICK_DIV must be at least 1");
      end else if (TICK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(TICK_DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt_q <= '0;
            else if (cnt_q == CW'(TICK_DIV - 1)) cnt_q <= '0;
            else                                 cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == CW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("STAGES must be at least 1");
      end else begin : g_chain
         logic [STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '1;
            else        sr_q <= {sr_q[STAGES-2:0], din};
         end
         assign dout = sr_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
   import serial_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 64,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              enable,
   input  logic              nine_en,
   input  logic              fifo_full,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              push_bit9,
   output logic              push_ferr,
   output logic              overrun
);
   localparam int CW   = $clog2(OVERSAMPLE);
   localparam int BW   = $clog2(DATA_W + 2);
   localparam int HALF = OVERSAMPLE / 2;

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_ovs
         $error("OVERSAMPLE must be even and at least 4");
      end
   endgenerate

   rx_state_e       st_q;
   logic [CW-1:0]   cnt_q;
   logic [BW-1:0]   bit_q;
   logic [DATA_W:0] sh_q;
   logic            nine_q;
   logic            ovr_q;
   logic            push_q;
   logic [DATA_W-1:0] data_q;
   logic            b9_q;
   logic            fe_q;
   logic [BW-1:0]   nbits;

   assign nbits = nine_q ? BW'(DATA_W + 1) : BW'(DATA_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         cnt_q  <= '0;
         bit_q  <= '0;
         sh_q   <= '0;
         nine_q <= 1'b0;
         ovr_q  <= 1'b0;
         push_q <= 1'b0;
         data_q <= '0;
         b9_q   <= 1'b0;
         fe_q   <= 1'b0;
      end else if (!enable) begin
         st_q   <= RX_IDLE;
         cnt_q  <= '0;
         ovr_q  <= 1'b0;
         push_q <= 1'b0;
      end else begin
         push_q <= 1'b0;
         if (tick) begin
            case (st_q)
               RX_IDLE: begin
                  cnt_q <= '0;
                  if (!line) st_q <= RX_START;
               end
               RX_START: begin
                  if (cnt_q == CW'(HALF - 1)) begin
                     cnt_q  <= '0;
                     bit_q  <= '0;
                     nine_q <= nine_en;
                     st_q   <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt_q == CW'(OVERSAMPLE - 1)) begin
                     cnt_q <= '0;
                     sh_q  <= {line, sh_q[DATA_W:1]};
                     bit_q <= bit_q + 1'b1;
                     if (bit_q + 1'b1 == nbits) st_q <= RX_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt_q == CW'(OVERSAMPLE - 1)) begin
                     cnt_q <= '0;
                     if (fifo_full) begin
                        ovr_q <= 1'b1;
                        st_q  <= RX_HALT;
                     end else begin
                        push_q <= 1'b1;
                        data_q <= nine_q ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
                        b9_q   <= nine_q & sh_q[DATA_W];
                        fe_q   <= ~line;
                        st_q   <= line ? RX_IDLE : RX_BREAK;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_BREAK: if (line) st_q <= RX_IDLE;
               RX_HALT:  st_q <= RX_HALT;
               default:  st_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign push      = push_q;
   assign push_data = data_q;
   assign push_bit9 = b9_q;
   assign push_ferr = fe_q;
   assign overrun   = ovr_q;

   AST_HALT_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> !push_q); // R7
   AST_BREAK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RX_BREAK && enable && !line) |=> (st_q == RX_BREAK)); // R5
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
   parameter int DEPTH = 2,
   parameter int W     = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad
         $error("DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [NW-1:0] cnt_q;
   logic          do_pop, do_push;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == NW'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & ~full;
   assign head    = mem_q[rp_q];

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             mem_q[gi] <= '0;
            else if (do_push && wp_q == PW'(gi))    mem_q[gi] <= din;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= nxt(wp_q);
         if (do_pop)  rp_q <= nxt(rp_q);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R7
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q + 1'b1 == $past(cnt_q))); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 64,
   parameter int TICK_DIV    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int QDEPTH      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic              rx_enable,
   input  logic              nine_bit_en,
   input  logic              irq_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_bit9,
   output logic              rd_frame_err,
   output logic              data_avail,
   output logic              overrun,
   output logic              irq
);
   localparam int EW = DATA_W + 2;

   logic              tick, line_s, q_full, q_empty, push, pb9, pfe;
   logic [DATA_W-1:0] pdata;
   logic [EW-1:0]     q_head;

   serial_rx_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s));

   serial_rx_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
      .enable(rx_enable), .nine_en(nine_bit_en), .fifo_full(q_full),
      .push(push), .push_data(pdata), .push_bit9(pb9), .push_ferr(pfe),
      .overrun(overrun));

   serial_rx_queue #(.DEPTH(QDEPTH), .W(EW)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(push), .din({pfe, pb9, pdata}),
      .pop(rd_en), .head(q_head), .empty(q_empty), .full(q_full));

   assign rd_data      = q_head[DATA_W-1:0];
   assign rd_bit9      = q_head[DATA_W];
   assign rd_frame_err = q_head[DATA_W+1];
   assign data_avail   = ~q_empty;
   assign irq          = data_avail & irq_en;

   AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> !overrun); // R8
   AST_AVAIL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_avail) |-> $past(rd_en)); // R6
endmodule

// File: tb/serial_rx_fifo_bench.sv
module serial_rx_fifo_bench;
   localparam int OVS = 16;
   localparam int BIT = OVS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       rx_enable = 1'b1;
   logic       nine_bit_en = 1'b0;
   logic       irq_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_bit9, rd_frame_err, data_avail, overrun, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   serial_rx_fifo #(.DATA_W(8), .OVERSAMPLE(OVS), .TICK_DIV(1),
                    .SYNC_STAGES(2), .QDEPTH(2)) u_serial_rx_fifo (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_enable(rx_enable),
      .nine_bit_en(nine_bit_en), .irq_en(irq_en), .rd_en(rd_en),
      .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_frame_err(rd_frame_err),
      .data_avail(data_avail), .overrun(overrun), .irq(irq));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [8:0] v, input bit nine, input bit stop_ok);
      rx_line = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < (nine ? 9 : 8); i++) begin
         rx_line = v[i];
         repeat (BIT) @(negedge clk);
      end
      rx_line = stop_ok;
      repeat (BIT) @(negedge clk);
      rx_line = 1'b1;
      repeat (stop_ok ? 4 : BIT) @(negedge clk);
   endtask

   task automatic pop_chk(input logic [7:0] d, input bit b9, input bit fe, input string tag);
      chk(data_avail == 1'b1, {tag, " avail"}, data_avail, 1);
      chk(rd_data == d, {tag, " data"}, rd_data, d);
      chk(rd_bit9 == b9, {tag, " bit9"}, rd_bit9, b9);
      chk(rd_frame_err == fe, {tag, " ferr"}, rd_frame_err, fe);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(data_avail == 0, "R1 avail", data_avail, 0);
      chk(overrun == 0, "R1 overrun", overrun, 0);
      chk(irq == 0, "R1 irq", irq, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 R6: full byte sweep in complementary pairs
      for (int v = 0; v < 256; v += 2) begin
         send(9'(v), 1'b0, 1'b1);
         send(9'(255 - v), 1'b0, 1'b1);
         pop_chk(8'(v), 1'b0, 1'b0, "R2 first");
         pop_chk(8'(255 - v), 1'b0, 1'b0, "R6 second");
         chk(data_avail == 0, "R6 drained", data_avail, 0);
      end

      // R4: nine-bit stride sweep, neighbouring entries with different ninth bits
      nine_bit_en = 1'b1;
      for (int i = 0; i < 64; i += 2) begin
         logic [8:0] a, b;
         a = 9'((i * 37 + 5) % 512);
         b = a ^ 9'h100;
         send(a, 1'b1, 1'b1);
         send(b, 1'b1, 1'b1);
         pop_chk(a[7:0], a[8], 1'b0, "R4 a");
         pop_chk(b[7:0], b[8], 1'b0, "R4 b");
      end
      nine_bit_en = 1'b0;

      // R3: short low glitch is rejected
      rx_line = 1'b0;
      repeat (4) @(negedge clk);
      rx_line = 1'b1;
      repeat (3 * BIT) @(negedge clk);
      chk(data_avail == 0, "R3 glitch", data_avail, 0);
      send(9'h05A, 1'b0, 1'b1);
      pop_chk(8'h5A, 1'b0, 1'b0, "R3 after");

      // R5: bad stop bit, error belongs to its own entry
      send(9'h0C3, 1'b0, 1'b0);
      send(9'h03C, 1'b0, 1'b1);
      pop_chk(8'hC3, 1'b0, 1'b1, "R5 bad");
      pop_chk(8'h3C, 1'b0, 1'b0, "R5 good");
      chk(data_avail == 0, "R5 no extra", data_avail, 0);

      // R6: read on empty has no effect
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
      send(9'h011, 1'b0, 1'b1);
      pop_chk(8'h11, 1'b0, 1'b0, "R6 empty-read");
      chk(data_avail == 0, "R6 empty after", data_avail, 0);

      // R9: irq gating
      send(9'h077, 1'b0, 1'b1);
      chk(irq == 0, "R9 masked", irq, 0);
      irq_en = 1'b1; @(negedge clk);
      chk(irq == 1, "R9 raised", irq, 1);
      pop_chk(8'h77, 1'b0, 1'b0, "R9 pop");
      chk(irq == 0, "R9 dropped", irq, 0);
      irq_en = 1'b0;

      // R7: third frame into full queue
      send(9'h0A1, 1'b0, 1'b1);
      send(9'h0B2, 1'b0, 1'b1);
      chk(overrun == 0, "R7 not yet", overrun, 0);
      send(9'h0C3, 1'b0, 1'b1);
      chk(overrun == 1, "R7 set", overrun, 1);
      pop_chk(8'hA1, 1'b0, 1'b0, "R7 keep a");
      send(9'h0D4, 1'b0, 1'b1);
      pop_chk(8'hB2, 1'b0, 1'b0, "R7 keep b");
      chk(data_avail == 0, "R7 halted", data_avail, 0);
      chk(overrun == 1, "R7 sticky", overrun, 1);

      // R8: disable clears overrun, keeps queue, blocks reception
      send(9'h0E5, 1'b0, 1'b1);
      chk(data_avail == 0, "R8 halted", data_avail, 0);
      rx_enable = 1'b0; @(negedge clk);
      chk(overrun == 0, "R8 cleared", overrun, 0);
      rx_enable = 1'b1;
      send(9'h021, 1'b0, 1'b1);
      send(9'h032, 1'b0, 1'b1);
      send(9'h043, 1'b0, 1'b1);
      chk(overrun == 1, "R8 ovr again", overrun, 1);
      rx_enable = 1'b0; @(negedge clk);
      chk(overrun == 0, "R8 clear2", overrun, 0);
      send(9'h099, 1'b0, 1'b1);
      rx_enable = 1'b1; @(negedge clk);
      pop_chk(8'h21, 1'b0, 1'b0, "R8 kept a");
      pop_chk(8'h32, 1'b0, 1'b0, "R8 kept b");
      chk(data_avail == 0, "R8 disabled rx", data_avail, 0);
      send(9'h066, 1'b0, 1'b1);
      pop_chk(8'h66, 1'b0, 1'b0, "R8 resumed");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule